// File: doc/BRIEF.md
# Sparse Pixel Hit Readout with Skipping Token

This block holds the digital state of a two-dimensional pixel matrix and reads out only the pixels that fired. Each pixel keeps a hit flag and a copy of the shared time-stamp counter, taken on the cycle its hit strobe is seen. A readout pass starts on a one-cycle start pulse. A token then walks the matrix row by row, starting at row 0. Within a row it goes from column 0 upward and stops only at pixels that hold a hit.

The pixels store no address. Addresses come from the perimeter: one row counter, advanced when the token runs past the last column, and a column cursor inside the row. At each stop the perimeter forms a 30-bit word from the column, the row and the stored time stamp. It sends that word out serially with a valid strobe, then clears the pixel.

After the last row has been passed, a one-cycle done pulse ends the pass. For testing, a known hit pattern can be shifted into the matrix through a serial chain and then read back.

Top module: `sparse_pixel_readout`

## Requirements
- R1: Each word is 30 bits, sent MSB first. It holds the 10-bit column (0-based), then the 10-bit row (0-based), then the TS_W-bit time stamp, then zeros that fill bits below the time stamp (3 zeros for TS_W=7).
- R2: valid_o is high for exactly 30 consecutive cycles per word, with sout_o carrying one bit per cycle. It is low for at least one cycle between two words.
- R3: Words come out in row order from row 0 upward and, within a row, in increasing column order. A pixel without a hit produces no word.
- R4: A pixel whose flag is clear latches ts_cnt_i on the clock edge that samples its hit strobe high. Further strobes on a pixel that already holds a hit are ignored, and the first time stamp is kept.
- R5: A pixel is cleared after its word has been sent, so a second pass with no new hits produces no words.
- R6: A hit on a pixel that held no hit when the pass started is not reported in that pass. It is reported, with its own time stamp, in the next pass.
- R7: done_o is a single-cycle pulse. Count the clock edge that samples start_i as edge 1. The pulse appears after edge 1 + NROW + 31*H, where H is the number of reported hits.
- R8: With no hits in the matrix, done_o appears after edge 1 + NROW and valid_o never rises.
- R9: While the block is idle, each cycle with tst_shift_i high shifts the hit flags along the chain in pixel index order (index = row*NCOL + column). tst_din_i enters index 0. Every loaded pixel takes ts_cnt_i as its time stamp, so the bit shifted in first ends at the highest index.
- R10: start_i and tst_shift_i are ignored while a pass is in progress. They do not change the words, their order or the done timing.
- R11: After reset, sout_o, valid_o and done_o are low and no pixel holds a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | NROW*NCOL | Hit strobe per pixel, index row*NCOL+column |
| ts_cnt_i | input | TS_W | Shared time-stamp counter value |
| start_i | input | 1 | Start-of-readout pulse |
| tst_shift_i | input | 1 | Test pattern shift enable |
| tst_din_i | input | 1 | Test pattern serial input |
| sout_o | output | 1 | Serial word data, MSB first |
| valid_o | output | 1 | High while a word bit is on sout_o |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
Each word bit is due one cycle after the edge that moves the token onto the hit. Stepping from one row to the next costs one cycle, and each hit costs 31. The bench therefore predicts the exact cycle of the done pulse from the row count and the number of hits.

All outputs are sampled on the falling edge. The bench counts falling edges from the start edge and compares the count at done against 1 + NROW + 31*H. Inputs change only on the falling edge, so a hit strobe and its time stamp are taken on the next rising edge. This makes the bench's model of each stored time stamp exact.

// File: rtl/spr_pkg.sv
package spr_pkg;
   localparam int ADDR_W = 10;
   localparam int WORD_W = 30;

   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_SEARCH = 2'd1,
      RD_SHIFT  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/spr_pixel_array.sv
module spr_pixel_array #(
   parameter int NCOL = 16,
   parameter int NROW = 16,
   parameter int TS_W = 7,
   parameter int CW   = 4,
   parameter int RW   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NROW*NCOL-1:0]   hit_i,
   input  logic [TS_W-1:0]        ts_cnt_i,
   input  logic                   snap_i,
   input  logic                   load_en_i,
   input  logic                   load_din_i,
   input  logic [RW-1:0]          row_i,
   input  logic [CW-1:0]          rd_col_i,
   input  logic                   clr_en_i,
   input  logic [CW-1:0]          clr_col_i,
   output logic [NCOL-1:0]        row_armed_o,
   output logic [TS_W-1:0]        rd_ts_o
);
   localparam int NPIX = NROW * NCOL;
   localparam int PW   = (NPIX > 1) ? $clog2(NPIX) : 1;

   logic [NPIX-1:0] flag_vec;
   logic [NPIX-1:0] armed_vec;
   logic [TS_W-1:0] ts_arr [NPIX];
   logic [PW-1:0]   base_idx;
   logic [PW-1:0]   rd_idx;
   logic [PW-1:0]   clr_idx;

   assign base_idx = PW'(row_i) * PW'(NCOL);
   assign rd_idx   = base_idx + PW'(rd_col_i);
   assign clr_idx  = base_idx + PW'(clr_col_i);

   assign row_armed_o = armed_vec[base_idx +: NCOL];
   assign rd_ts_o     = ts_arr[rd_idx];

   for (genvar p = 0; p < NPIX; p++) begin : g_pix
      logic            flag_q;
      logic            armed_q;
      logic [TS_W-1:0] ts_q;
      logic            chain_in;
      logic            clr_me;
      logic            hit_new;

      if (p == 0) begin : g_head
         assign chain_in = load_din_i;
      end else begin : g_link
         assign chain_in = flag_vec[p-1];
      end

      assign clr_me  = clr_en_i && (clr_idx == PW'(p));
      assign hit_new = hit_i[p] && (!flag_q || clr_me);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            ts_q    <= '0;
         end else if (load_en_i) begin
            flag_q  <= chain_in;
            armed_q <= 1'b0;
            ts_q    <= ts_cnt_i;
         end else begin
            if (snap_i)
               armed_q <= flag_q;
            else if (clr_me)
               armed_q <= 1'b0;
            if (hit_new) begin
               flag_q <= 1'b1;
               ts_q   <= ts_cnt_i;
            end else if (clr_me) begin
               flag_q <= 1'b0;
            end
         end
      end

      assign flag_vec[p]  = flag_q;
      assign armed_vec[p] = armed_q;
      assign ts_arr[p]    = ts_q;
   end

   // R6
   armed_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_vec & ~flag_vec) == '0);

   // R5
   clr_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_i |-> armed_vec[clr_idx]);

   // R5
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && !hit_i[clr_idx]) |=> !flag_vec[$past(clr_idx)]);
endmodule

// File: rtl/spr_row_scan.sv
module spr_row_scan #(
   parameter int NCOL = 16,
   parameter int CW   = 4
) (
   input  logic [NCOL-1:0] bits_i,
   input  logic [CW:0]     cursor_i,
   output logic            found_o,
   output logic [CW-1:0]   col_o
);
   always_comb begin
      found_o = 1'b0;
      col_o   = '0;
      for (int c = NCOL - 1; c >= 0; c--) begin
         if (bits_i[c] && ((CW+1)'(c) >= cursor_i)) begin
            found_o = 1'b1;
            col_o   = CW'(c);
         end
      end
   end

   // R3
   always_comb begin
      if (found_o) begin
         scan_hit_chk: assert ((bits_i[col_o] == 1'b1) && ({1'b0, col_o} >= cursor_i));
      end
   end
endmodule

// File: rtl/spr_word_shifter.sv
module spr_word_shifter #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              bit_o,
   output logic              valid_o,
   output logic              last_o
);
   localparam int CNT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] sreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q   <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load_i) begin
         sreg_q   <= word_i;
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
         cnt_q  <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(WORD_W - 1))
            active_q <= 1'b0;
      end
   end

   assign bit_o   = active_q & sreg_q[WORD_W-1];
   assign valid_o = active_q;
   assign last_o  = active_q && (cnt_q == CNT_W'(WORD_W - 1));

   // R2
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o) |=> valid_o);

   // R2
   word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !valid_o);

   // R2
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !valid_o);
endmodule

// File: rtl/sparse_pixel_readout.sv
module sparse_pixel_readout
   import spr_pkg::*;
#(
   parameter int NCOL = 16,
   parameter int NROW = 16,
   parameter int TS_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NROW*NCOL-1:0] hit_i,
   input  logic [TS_W-1:0]      ts_cnt_i,
   input  logic                 start_i,
   input  logic                 tst_shift_i,
   input  logic                 tst_din_i,
   output logic                 sout_o,
   output logic                 valid_o,
   output logic                 done_o
);
   localparam int CW  = (NCOL > 1) ? $clog2(NCOL) : 1;
   localparam int RW  = (NROW > 1) ? $clog2(NROW) : 1;
   localparam int PAD = WORD_W - 2 * ADDR_W - TS_W;

   if (NCOL < 1 || NCOL > 1000) begin : g_bad_ncol
      $error("NCOL out of range 1..1000");
   end
   if (NROW < 1 || NROW > 1000) begin : g_bad_nrow
      $error("NROW out of range 1..1000");
   end
   if (TS_W < 1 || PAD < 0) begin : g_bad_ts
      $error("TS_W does not fit the word");
   end

   rd_state_e         state_q;
   logic [RW-1:0]     row_q;
   logic [CW:0]       cursor_q;
   logic [CW-1:0]     col_q;
   logic              done_q;

   logic              idle;
   logic              snap;
   logic              load_en;
   logic [NCOL-1:0]   row_armed;
   logic [TS_W-1:0]   rd_ts;
   logic              found;
   logic [CW-1:0]     scan_col;
   logic              word_load;
   logic              word_last;
   logic              clr_en;
   logic [WORD_W-1:0] word;
   logic [ADDR_W-1:0] x_addr;
   logic [ADDR_W-1:0] y_addr;
   logic              row_last;

   assign idle      = (state_q == RD_IDLE);
   assign snap      = idle && start_i;
   assign load_en   = idle && !start_i && tst_shift_i;
   assign word_load = (state_q == RD_SEARCH) && found;
   assign clr_en    = (state_q == RD_SHIFT) && word_last;
   assign row_last  = (row_q == RW'(NROW - 1));

   spr_pixel_array #(
      .NCOL(NCOL), .NROW(NROW), .TS_W(TS_W), .CW(CW), .RW(RW)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit_i),
      .ts_cnt_i   (ts_cnt_i),
      .snap_i     (snap),
      .load_en_i  (load_en),
      .load_din_i (tst_din_i),
      .row_i      (row_q),
      .rd_col_i   (scan_col),
      .clr_en_i   (clr_en),
      .clr_col_i  (col_q),
      .row_armed_o(row_armed),
      .rd_ts_o    (rd_ts)
   );

   spr_row_scan #(.NCOL(NCOL), .CW(CW)) u_scan (
      .bits_i  (row_armed),
      .cursor_i(cursor_q),
      .found_o (found),
      .col_o   (scan_col)
   );

   assign x_addr = ADDR_W'(scan_col);
   assign y_addr = ADDR_W'(row_q);

   if (PAD > 0) begin : g_pad
      assign word = {x_addr, y_addr, rd_ts, {PAD{1'b0}}};
   end else begin : g_nopad
      assign word = {x_addr, y_addr, rd_ts};
   end

   spr_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (word_load),
      .word_i (word),
      .bit_o  (sout_o),
      .valid_o(valid_o),
      .last_o (word_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RD_IDLE;
         row_q    <= '0;
         cursor_q <= '0;
         col_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RD_IDLE: begin
               if (start_i) begin
                  row_q    <= '0;
                  cursor_q <= '0;
                  state_q  <= RD_SEARCH;
               end
            end
            RD_SEARCH: begin
               if (found) begin
                  col_q   <= scan_col;
                  state_q <= RD_SHIFT;
               end else if (row_last) begin
                  done_q  <= 1'b1;
                  state_q <= RD_IDLE;
               end else begin
                  row_q    <= row_q + 1'b1;
                  cursor_q <= '0;
               end
            end
            RD_SHIFT: begin
               if (word_last) begin
                  cursor_q <= {1'b0, col_q} + 1'b1;
                  state_q  <= RD_SEARCH;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign done_o = done_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && start_i && state_q == RD_SEARCH && !found && !row_last)
         |=> (row_q == $past(row_q) + 1'b1));

   // R3
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_SHIFT) |-> (row_q == $past(row_q)));
endmodule

// File: tb/tb_sparse_pixel_readout.sv
module tb_sparse_pixel_readout;
   localparam int CLK_PERIOD = 10;
   localparam int NC   = 7;
   localparam int NR   = 5;
   localparam int TSW  = 7;
   localparam int NPIX = NC * NR;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIX-1:0] hit_i = '0;
   logic [TSW-1:0]  ts_cnt_i = '0;
   logic            start_i = 1'b0;
   logic            tst_shift_i = 1'b0;
   logic            tst_din_i = 1'b0;
   logic            sout_o, valid_o, done_o;

   int total = 0;
   int bad = 0;
   bit ended = 0;

   bit             m_flag [NPIX];
   logic [TSW-1:0] m_ts   [NPIX];

   always #(CLK_PERIOD/2) clk = ~clk;

   sparse_pixel_readout #(.NCOL(NC), .NROW(NR), .TS_W(TSW)) dut (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_cnt_i(ts_cnt_i),
      .start_i(start_i), .tst_shift_i(tst_shift_i), .tst_din_i(tst_din_i),
      .sout_o(sout_o), .valid_o(valid_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [29:0] make_word(input int x, input int y, input logic [TSW-1:0] ts);
      return {10'(x), 10'(y), ts, 3'b000};
   endfunction

   // R4: hits taken only on pixels not yet flagged
   task automatic apply_hits(input logic [NPIX-1:0] vec, input logic [TSW-1:0] tsv);
      @(negedge clk);
      hit_i = vec;
      ts_cnt_i = tsv;
      for (int p = 0; p < NPIX; p++)
         if (vec[p] && !m_flag[p]) begin
            m_flag[p] = 1'b1;
            m_ts[p] = tsv;
         end
      @(negedge clk);
      hit_i = '0;
   endtask

   // R9: shift a pattern through the test chain
   task automatic load_pattern(input logic [NPIX-1:0] pat, input logic [TSW-1:0] tsv);
      for (int i = NPIX - 1; i >= 0; i--) begin
         @(negedge clk);
         tst_shift_i = 1'b1;
         tst_din_i = pat[i];
         ts_cnt_i = tsv;
      end
      @(negedge clk);
      tst_shift_i = 1'b0;
      tst_din_i = 1'b0;
      for (int p = 0; p < NPIX; p++) begin
         m_flag[p] = pat[p];
         m_ts[p] = tsv;
      end
   endtask

   task automatic run_readout(input string tag, input int inj_p, input int inj_at, input int poke_at);
      logic [29:0] expw [NPIX];
      bit          snap [NPIX];
      int          h;
      int          widx;
      int          nb;
      bit          gap_due;
      bit          got_done;
      bit          do_inj;
      logic [29:0] shreg;
      logic [TSW-1:0] inj_ts;
      h = 0; widx = 0; nb = 0; gap_due = 0; got_done = 0; shreg = '0;
      inj_ts = 7'h55;
      for (int p = 0; p < NPIX; p++) begin
         snap[p] = m_flag[p];
         if (m_flag[p]) begin
            expw[h] = make_word(p % NC, p / NC, m_ts[p]);
            h++;
         end
      end
      do_inj = (inj_p >= 0) && !snap[inj_p];
      @(negedge clk);
      start_i = 1'b1;
      for (int c = 1; c < 4000; c++) begin
         @(negedge clk);
         if (c == 1) start_i = 1'b0;
         if (do_inj && c == inj_at) begin
            hit_i[inj_p] = 1'b1;
            ts_cnt_i = inj_ts;
         end
         if (do_inj && c == inj_at + 1) hit_i = '0;
         if (c == poke_at) begin
            start_i = 1'b1;
            tst_shift_i = 1'b1;
            tst_din_i = 1'b1;
         end
         if (c == poke_at + 1) begin
            start_i = 1'b0;
            tst_shift_i = 1'b0;
            tst_din_i = 1'b0;
         end
         if (gap_due) begin
            // R2: valid drops between words
            check(!valid_o, {tag, " R2 gap"}, 32'(valid_o), 32'd0);
            gap_due = 0;
         end
         if (valid_o) begin
            shreg = {shreg[28:0], sout_o};
            nb++;
            if (nb == 30) begin
               // R1 R3: word content and order
               if (widx < h)
                  check(shreg == expw[widx], {tag, " R1/R3 word"}, 32'(shreg), 32'(expw[widx]));
               else
                  check(1'b0, {tag, " R3 extra word"}, 32'(shreg), 32'd0);
               widx++;
               nb = 0;
               gap_due = 1;
            end
         end
         if (done_o) begin
            // R7: done timing
            check(c == 1 + NR + 31 * h, {tag, " R7 done cycle"}, 32'(c), 32'(1 + NR + 31 * h));
            // R3: word count
            check(widx == h && nb == 0, {tag, " R3 count"}, 32'(widx), 32'(h));
            got_done = 1;
            @(negedge clk);
            // R7: single-cycle pulse
            check(!done_o, {tag, " R7 pulse"}, 32'(done_o), 32'd0);
            break;
         end
      end
      if (!got_done) check(1'b0, {tag, " R7 no done"}, 32'd0, 32'd1);
      for (int p = 0; p < NPIX; p++)
         if (snap[p]) m_flag[p] = 1'b0;
      if (do_inj) begin
         m_flag[inj_p] = 1'b1;
         m_ts[inj_p] = inj_ts;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         bad++;
         total++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NPIX-1:0] v;
      void'($urandom(32'd4711));
      for (int p = 0; p < NPIX; p++) begin
         m_flag[p] = 0;
         m_ts[p] = '0;
      end
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!sout_o && !valid_o && !done_o, "R11 reset outputs", {29'd0, sout_o, valid_o, done_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 R11: empty matrix after reset
      run_readout("R8 empty", -1, 0, -5);

      // R1: corners and time stamps
      apply_hits(NPIX'(1) << 0, 7'h7F);
      apply_hits(NPIX'(1) << (NPIX - 1), 7'h01);
      run_readout("R1 corners", -1, 0, -5);

      // R4: re-strobe keeps first stamp
      apply_hits(NPIX'(1) << 9, 7'h21);
      apply_hits(NPIX'(1) << 9, 7'h3C);
      run_readout("R4 restrobe", -1, 0, -5);

      // R5: second pass with nothing new
      run_readout("R5 cleared", -1, 0, -5);

      // R6: hit during readout, held for next pass
      apply_hits((NPIX'(1) << 3) | (NPIX'(1) << 20), 7'h12);
      run_readout("R6 pass1", 30, 10, -5);
      run_readout("R6 pass2", -1, 0, -5);

      // R10: start and shift while busy ignored
      apply_hits((NPIX'(1) << 1) | (NPIX'(1) << 2) | (NPIX'(1) << 34), 7'h44);
      run_readout("R10 poke", -1, 0, 3);
      run_readout("R10 after", -1, 0, -5);

      // R9: test pattern load
      v = '0;
      for (int p = 0; p < NPIX; p++) v[p] = ((p % 3) == 0);
      load_pattern(v, 7'h5A);
      run_readout("R9 pattern", -1, 0, -5);
      load_pattern({NPIX{1'b1}}, 7'h06);
      run_readout("R9 full", -1, 0, -5);

      // random rounds (R3 R4 R6)
      for (int r = 0; r < 6; r++) begin
         v = '0;
         for (int p = 0; p < NPIX; p++) v[p] = (($urandom % 4) == 0);
         apply_hits(v, TSW'($urandom));
         v = '0;
         for (int p = 0; p < NPIX; p++) v[p] = (($urandom % 6) == 0);
         apply_hits(v, TSW'($urandom));
         run_readout("R3 random", int'($urandom % NPIX), 4 + int'($urandom % 40), -5);
      end
      run_readout("R6 final", -1, 0, -5);

      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule